// File: doc/BRIEF.md
# Timestamped cluster sample expander

This block turns the contents of capture memory into an uninterrupted stream of samples. Memory arrives as 16-bit words grouped in clusters: one 16-bit timestamp followed by seven 16-bit event words. A chunk holds a fixed number of clusters. Each event word carries one, two or four consecutive samples, depending on how many channels the capture used. The block unpacks them in time order. When the timestamp advances by more than a cluster's worth of time, the gap stands for idle time. The block fills that gap by repeating the most recent sample.

A controller loads the channel mode and an optional stop timestamp with a one-cycle start pulse. It then streams the chunk's words in with a valid/ready handshake and takes samples out through a second valid/ready handshake. Decoding ends after the last cluster of the chunk. It ends earlier if a stop timestamp is set and a cluster's timestamp lies beyond it. In either case the block returns to idle and waits for the next start.

Top module: `ts_cluster_expander`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are both 0 until `start` is seen.
- R2: `start` in idle captures `mode` and `limit_ts`. Later changes on those inputs have no effect until the next start. The block never requests an input word while it offers a sample.
- R3: In mode 0 (16 channels), each event word yields exactly one sample, equal to the event word.
- R4: In mode 1 (8 channels), each event word yields two samples, k = 0 then k = 1. Bit l of sample k is event bit 2·l+k, and bits 15..8 are 0.
- R5: In modes 2 and 3 (4 channels), each event word yields four samples, k = 0 to 3. Bit l of sample k is event bit 4·l+k, and bits 15..4 are 0.
- R6: The first cluster after start is never preceded by padding.
- R7: Before a later cluster, the block emits the last emitted sample (gap − 7)·S times, where gap is the timestamp difference and S is the samples per event. It emits none when gap ≤ 7.
- R8: The timestamp difference is taken modulo 2^16, so a timestamp that wraps past 0xFFFF still yields the correct gap.
- R9: With a nonzero `limit_ts`, a cluster whose timestamp is greater than the limit is consumed as a single word. No further sample is produced and the block returns to idle. A timestamp equal to the limit is decoded normally.
- R10: A `limit_ts` of 0 disables the stop check.
- R11: After `CHUNK_CLUSTERS` complete clusters, the block returns to idle with `in_ready` low.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding a chunk (honoured in idle) |
| mode | input | 2 | Channel mode: 0 = 16×1, 1 = 8×2, 2/3 = 4×4 |
| limit_ts | input | 16 | Stop timestamp, 0 = none |
| in_word | input | 16 | Memory word (timestamp or event) |
| in_valid | input | 1 | `in_word` is valid |
| in_ready | output | 1 | Block accepts `in_word` this cycle |
| out_data | output | 16 | Sample, zero-extended above the active channels |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Consumer accepts the sample |

## Verification
A word is taken on the rising edge where `in_valid` and `in_ready` are both high. The first resulting sample is offered from the next cycle on. After that, one sample leaves on each edge where `out_valid` and `out_ready` are high. The bench drives and observes only at falling edges. It counts a transfer only when both handshake signals are seen high there, so every comparison is tied to the edge that moves the data, however the stalls fall. The sample stream is compared in order with a list built arithmetically from the cluster timestamps, the event words and the mode. After the final expected sample, the bench confirms that no extra sample appears and that the block no longer requests input.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

    localparam int TSX_W = 16;

    typedef enum logic [1:0] {
        MODE_16X1 = 2'd0,
        MODE_8X2  = 2'd1,
        MODE_4X4  = 2'd2,
        MODE_4X4B = 2'd3
    } tsx_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STAMP,
        S_PAD,
        S_FETCH,
        S_EMIT
    } tsx_state_e;

    typedef struct packed {
        tsx_mode_e         mode;
        logic [TSX_W-1:0]  limit;
    } tsx_cfg_t;

    // log2 of samples carried by one event word
    function automatic logic [1:0] spe_shift(tsx_mode_e m);
        case (m)
            MODE_16X1: return 2'd0;
            MODE_8X2:  return 2'd1;
            default:   return 2'd2;
        endcase
    endfunction

    // index of the final sample within one event word
    function automatic logic [1:0] spe_last(tsx_mode_e m);
        case (m)
            MODE_16X1: return 2'd0;
            MODE_8X2:  return 2'd1;
            default:   return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/tsx_gap_calc.sv
module tsx_gap_calc
    import tsx_pkg::*;
#(
    parameter int W      = TSX_W,
    parameter int EVENTS = 7,
    parameter int PAD_W  = W + 3
) (
    input  logic [W-1:0]     ts,
    input  logic [W-1:0]     prev,
    input  logic             first,
    input  logic [1:0]       shift,
    output logic [PAD_W-1:0] pad_len
);
    logic [W-1:0]     gap;
    logic [PAD_W-1:0] excess;

    always_comb begin
        gap    = first ? W'(1) : (ts - prev);
        excess = PAD_W'(gap) - PAD_W'(EVENTS);
        if (gap > W'(EVENTS))
            pad_len = excess << shift;
        else
            pad_len = '0;
    end
endmodule

// File: rtl/tsx_lane_unpack.sv
module tsx_lane_unpack
    import tsx_pkg::*;
#(
    parameter int W = TSX_W
) (
    input  logic [W-1:0] ev,
    input  tsx_mode_e    mode,
    input  logic [1:0]   k,
    output logic [W-1:0] smp
);
    logic [W-1:0] s1, s2, s4;

    genvar l;
    generate
        for (l = 0; l < W; l++) begin : g_lane
            assign s1[l] = ev[l];
            if (l < W/2) begin : g_pair
                assign s2[l] = k[0] ? ev[2*l+1] : ev[2*l];
            end else begin : g_pair_zero
                assign s2[l] = 1'b0;
            end
            if (l < W/4) begin : g_quad
                logic [3:0] quad;
                assign quad  = ev[4*l+3 : 4*l];
                assign s4[l] = quad[k];
            end else begin : g_quad_zero
                assign s4[l] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        case (mode)
            MODE_16X1: smp = s1;
            MODE_8X2:  smp = s2;
            default:   smp = s4;
        endcase
    end
endmodule

// File: rtl/ts_cluster_expander.sv
module ts_cluster_expander
    import tsx_pkg::*;
#(
    parameter int CHUNK_CLUSTERS     = 64,
    parameter int EVENTS_PER_CLUSTER = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [TSX_W-1:0] limit_ts,
    input  logic [TSX_W-1:0] in_word,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [TSX_W-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready
);
    localparam int PAD_W = TSX_W + 3;
    localparam int CLU_W = (CHUNK_CLUSTERS > 1) ? $clog2(CHUNK_CLUSTERS) : 1;
    localparam int EV_W  = $clog2(EVENTS_PER_CLUSTER + 1);

    tsx_state_e       st;
    tsx_cfg_t         cfg_q;
    logic [TSX_W-1:0] prev_q, last_q, ev_q;
    logic             first_q;
    logic [PAD_W-1:0] pad_q, pad_len;
    logic [1:0]       k_q;
    logic [EV_W-1:0]  ev_idx_q;
    logic [CLU_W-1:0] clu_q;
    logic [TSX_W-1:0] unpacked;
    logic             past_limit;

    tsx_gap_calc #(.W(TSX_W), .EVENTS(EVENTS_PER_CLUSTER), .PAD_W(PAD_W)) u_gap (
        .ts      (in_word),
        .prev    (prev_q),
        .first   (first_q),
        .shift   (spe_shift(cfg_q.mode)),
        .pad_len (pad_len)
    );

    tsx_lane_unpack #(.W(TSX_W)) u_unpack (
        .ev   (ev_q),
        .mode (cfg_q.mode),
        .k    (k_q),
        .smp  (unpacked)
    );

    assign past_limit = (cfg_q.limit != '0) && (in_word > cfg_q.limit);
    assign in_ready   = (st == S_STAMP) || (st == S_FETCH);
    assign out_valid  = (st == S_PAD) || (st == S_EMIT);
    assign out_data   = (st == S_PAD) ? last_q : unpacked;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cfg_q    <= '0;
            prev_q   <= '0;
            last_q   <= '0;
            ev_q     <= '0;
            first_q  <= 1'b1;
            pad_q    <= '0;
            k_q      <= '0;
            ev_idx_q <= '0;
            clu_q    <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    cfg_q.mode  <= tsx_mode_e'(mode);
                    cfg_q.limit <= limit_ts;
                    first_q     <= 1'b1;
                    last_q      <= '0;
                    clu_q       <= '0;
                    st          <= S_STAMP;
                end
                S_STAMP: if (in_valid) begin
                    if (past_limit) begin
                        st <= S_IDLE;
                    end else begin
                        prev_q   <= in_word;
                        first_q  <= 1'b0;
                        pad_q    <= pad_len;
                        ev_idx_q <= '0;
                        st       <= (pad_len != '0) ? S_PAD : S_FETCH;
                    end
                end
                S_PAD: if (out_ready) begin
                    pad_q <= pad_q - 1'b1;
                    if (pad_q == PAD_W'(1)) st <= S_FETCH;
                end
                S_FETCH: if (in_valid) begin
                    ev_q <= in_word;
                    k_q  <= '0;
                    st   <= S_EMIT;
                end
                S_EMIT: if (out_ready) begin
                    last_q <= unpacked;
                    if (k_q == spe_last(cfg_q.mode)) begin
                        k_q <= '0;
                        if (ev_idx_q == EV_W'(EVENTS_PER_CLUSTER - 1)) begin
                            clu_q <= clu_q + 1'b1;
                            st    <= (clu_q == CLU_W'(CHUNK_CLUSTERS - 1)) ? S_IDLE : S_STAMP;
                        end else begin
                            ev_idx_q <= ev_idx_q + 1'b1;
                            st       <= S_FETCH;
                        end
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R12

    AST_ZERO_EXT_EIGHT: assert property (@(posedge clk) disable iff (rst)
        out_valid && cfg_q.mode == MODE_8X2 |-> out_data[15:8] == 8'h00); // R4

    AST_ZERO_EXT_FOUR: assert property (@(posedge clk) disable iff (rst)
        out_valid && cfg_q.mode[1] |-> out_data[15:4] == 12'h000); // R5

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R2

    AST_LIMIT_STOP: assert property (@(posedge clk) disable iff (rst)
        st == S_STAMP && in_valid && past_limit |=> !in_ready && !out_valid); // R9

endmodule

// File: tb/ts_cluster_expander_test.sv
module ts_cluster_expander_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] limit_ts = 16'd0;
    logic [15:0] in_word = 16'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;

    localparam int NCLU = 4;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    int          ts_list[NCLU];
    logic [15:0] words[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    ts_cluster_expander #(.CHUNK_CLUSTERS(NCLU), .EVENTS_PER_CLUSTER(7)) uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .limit_ts(limit_ts),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ev_of(int seed, int c, int e);
        return 16'((c * 7 + e + 1) * 16'h2b5d ^ seed);
    endfunction

    function automatic logic [15:0] sample_of(logic [15:0] ev, int spe, int k);
        logic [15:0] s = '0;
        for (int l = 0; l < 16 / spe; l++) s[l] = ev[l * spe + k];
        return s;
    endfunction

    task automatic build(int md, int lim, int seed, string mreq);
        int spe = (md == 0) ? 1 : (md == 1) ? 2 : 4;
        int prev = 0;
        logic [15:0] last = '0;
        words.delete(); exp_q.delete(); tag_q.delete();
        for (int c = 0; c < NCLU; c++) begin
            int ts = ts_list[c];
            int gap;
            words.push_back(16'(ts));
            if (lim != 0 && ts > lim) break;
            gap = (c == 0) ? 1 : ((ts - prev) & 16'hffff);
            if (gap > 7)
                for (int p = 0; p < (gap - 7) * spe; p++) begin
                    exp_q.push_back(last); tag_q.push_back("R7");
                end
            prev = ts;
            for (int e = 0; e < 7; e++) begin
                logic [15:0] ev = ev_of(seed, c, e);
                words.push_back(ev);
                for (int k = 0; k < spe; k++) begin
                    last = sample_of(ev, spe, k);
                    exp_q.push_back(last); tag_q.push_back(mreq);
                end
            end
        end
    endtask

    task automatic run_case(int md, int md_after, int lim, string endreq);
        int widx = 0;
        int got = 0;
        int guard = 0;
        bit hold = 0;
        logic [15:0] held = '0;
        @(negedge clk);
        mode = 2'(md); limit_ts = 16'(lim); start = 1'b1;
        @(negedge clk);
        start = 1'b0; mode = 2'(md_after); limit_ts = 16'h0001; // R2: ignored after start
        while ((got < exp_q.size() || widx < words.size()) && guard < 5000) begin
            @(negedge clk);
            cyc++; guard++;
            out_ready = (cyc % 4) != 2;
            if (hold) check(out_data == held, "R12", out_data, held);
            if (out_valid && out_ready) begin
                if (got < exp_q.size())
                    check(out_data == exp_q[got], tag_q[got], out_data, exp_q[got]);
                else
                    check(1'b0, "R2", out_data, 0);
                got++;
            end
            hold = out_valid && !out_ready;
            held = out_data;
            if (widx < words.size() && (cyc % 5) != 3) begin
                in_valid = 1'b1;
                in_word = words[widx];
                if (in_ready) widx++;
            end else begin
                in_valid = 1'b0;
            end
        end
        check(guard < 5000, endreq, guard, 0);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!out_valid && !in_ready, endreq, {out_valid, in_ready}, 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!out_valid && !in_ready, "R1", {out_valid, in_ready}, 0);

        // 16x1, gaps 8/7/10, limit disabled (R3 R6 R7 R10 R11)
        ts_list = '{100, 108, 115, 125};
        build(0, 0, 16'h0f0f, "R3");
        run_case(0, 1, 0, "R11");

        // 8x2 with mode input changed after start (R2 R4)
        ts_list = '{10, 20, 27, 35};
        build(1, 0, 16'ha5c3, "R4");
        run_case(1, 0, 0, "R2");

        // 4x4 with timestamp wrap (R5 R8)
        ts_list = '{16'hfffe, 16'h0008, 16'h000f, 16'h0010};
        build(2, 0, 16'h3c96, "R8");
        run_case(2, 0, 0, "R5");

        // mode 3, limit: equal decoded, greater stops (R9)
        ts_list = '{16'h20, 16'h30, 16'h31, 16'h40};
        build(3, 16'h30, 16'h7e11, "R5");
        run_case(3, 0, 16'h30, "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule